// File: doc/BRIEF.md
# DMA Burst and Boundary Scheduler

This block paces a DMA transfer between a word FIFO and a serial flash engine. Software sets up a byte count, a burst size, a device address, a boundary code, a time budget, a priority mode and the transfer direction, then pulses `start`. The scheduler waits until the FIFO fill level crosses the threshold for the active direction. It then asks the bus for one transaction whose length never runs past the remaining byte count, the burst size or the next device-address boundary. It counts bytes as the bus acknowledges them and repeats until nothing is left.

Each bus transaction can also be cut short by a time budget, counted in 100 ns steps. The unmoved bytes are then asked for again in a new transaction. A scrambled transfer whose device address is not word aligned is refused with an error flag. Request priority is low, high, or raised automatically once the FIFO runs dry on a write or fills up on a read.

Top module: `dma_burst_sched`

## Requirements
- R1: A `start` pulse is taken only while `busy` is 0. `busy` rises on the edge after an accepted start. A start while `busy` is 1 changes nothing.
- R2: For a device read (`dir_wr`=0), a request is raised only when `fifo_level` is strictly greater than `rx_thresh`.
- R3: For a device write (`dir_wr`=1), a request is raised only when `fifo_level` is strictly less than `tx_thresh`.
- R4: `req_bytes` equals the smallest of the burst size, the remaining byte count and the bytes left before the next boundary. A burst size of 0 means 256 bytes.
- R5: Boundary code c from 1 to 10 makes the boundary 16<<c bytes (32 B to 16 KB), and no transaction crosses a multiple of it. Code 0, and any code above 10, disables splitting.
- R6: With a nonzero `time_limit` L, a transaction that has spent L*10 clock cycles with `xfer_active` high ends, even if bytes are still outstanding. The bytes it did not move are requested again. L=0 disables the cut.
- R7: Each `beat` while `xfer_active` is 1 moves one byte, advances the address by one and lowers the remaining count by one. A `beat` at any other time is ignored.
- R8: On the edge where the remaining count reaches 0, `busy` falls and `done` rises. `done` holds until the next accepted start.
- R9: A start with a total count of 0 sets `done` on the next edge, with no request and without raising `busy`.
- R10: A start with `scramble` set and `dev_addr[1:0]` nonzero sets `err` on the next edge, leaving `busy` and `done` at 0. An aligned scrambled start proceeds normally.
- R11: `prio_sel` is 0 for low, 1 for high, 2 for automatic, and 3 acts as low. `prio_high` is 0 when idle and 1 while busy in high mode. In automatic mode it is 1 from the edge after the FIFO is seen empty on a write or full (`FIFO_DEPTH` entries) on a read, until the transfer ends.
- R12: Once `req_valid` is raised, it stays high with `req_addr` and `req_bytes` unchanged until the edge where `req_ready` is sampled high.
- R13: After reset, `busy`, `done`, `err`, `req_valid`, `xfer_active` and `prio_high` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| dir_wr | input | 1 | 1 = memory to device (TX FIFO), 0 = device to memory (RX FIFO) |
| total_bytes | input | CNT_W (24) | Total byte count |
| burst_bytes | input | BURST_W (8) | Burst size in bytes, 0 means 256 |
| dev_addr | input | ADDR_W (32) | Starting device byte address |
| bound_code | input | BC_W (4) | Boundary selector |
| time_limit | input | TL_W (12) | Per-transaction budget in 100 ns steps, 0 = off |
| prio_sel | input | 2 | Priority mode |
| scramble | input | 1 | Transfer is scrambled (needs word alignment) |
| fifo_level | input | LVL_W (6) | FIFO fill level in words |
| tx_thresh | input | LVL_W (6) | Write-direction trigger level |
| rx_thresh | input | LVL_W (6) | Read-direction trigger level |
| req_ready | input | 1 | Bus accepts the pending request |
| beat | input | 1 | Bus moved one byte of the current transaction |
| req_valid | output | 1 | A transaction request is pending |
| req_addr | output | ADDR_W (32) | Device address of the request |
| req_bytes | output | BURST_W+1 (9) | Length of the request in bytes |
| xfer_active | output | 1 | A transaction is moving data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed |
| err | output | 1 | Scrambling alignment error |
| prio_high | output | 1 | Raised request priority |

## Verification
The splitting rule is tried with a burst-limited read, a start address just below a 32-byte boundary, the 16 KB boundary with an address close to it, an out-of-range code, and a burst size of 0. Each case brings a different term of the minimum into play, so a wrong term or a wrong shift shows up as a different request list. Level gating is tried with the FIFO held on the wrong side of a threshold and then moved across it, which separates the strict comparisons of the two directions. Alternating beats under a short time budget show that transactions are cut and resumed. Stray beats outside transactions, a second start mid-transfer and a delayed `req_ready` show that these inputs are ignored or held as required.

// File: rtl/dbs_pkg.sv
// Shared types for the DMA burst scheduler.
package dbs_pkg;
    typedef enum logic [1:0] {
        PRIO_LOW  = 2'd0,
        PRIO_HIGH = 2'd1,
        PRIO_AUTO = 2'd2,
        PRIO_RSVD = 2'd3
    } prio_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_MOVE  = 2'd3
    } sched_st_e;
endpackage

// File: rtl/dbs_len_calc.sv
// Transaction length: the smallest of the burst size, the remaining count and the
// bytes left before the next device-address boundary.
// Assumes CNT_W is wider than both BURST_W+1 and the widest boundary span.
module dbs_len_calc #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 24,
    parameter int BURST_W   = 8,
    parameter int BC_W      = 4,
    parameter int BCODE_MAX = 10,
    localparam int LEN_W    = BURST_W + 1,
    localparam int BOUND_W  = BCODE_MAX + 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   remaining,
    input  logic [BURST_W-1:0] burst,
    input  logic [BC_W-1:0]    bcode,
    output logic [LEN_W-1:0]   len
);
    logic [LEN_W-1:0]   burst_eff;
    logic [BOUND_W-1:0] span;
    logic [BOUND_W-1:0] offs;
    logic [BOUND_W-1:0] left;
    logic               bound_on;
    logic [CNT_W-1:0]   pick;

    // Minimum of the three limits; a code outside 1..BCODE_MAX disables the boundary.
    always_comb begin
        burst_eff = (burst == '0) ? {1'b1, {BURST_W{1'b0}}} : {1'b0, burst};
        bound_on  = (bcode != '0) && (bcode <= BC_W'(BCODE_MAX));
        span      = BOUND_W'(16) << bcode;
        offs      = addr[BOUND_W-1:0] & (span - BOUND_W'(1));
        left      = span - offs;
        pick      = CNT_W'(burst_eff);
        if (remaining < pick) pick = remaining;
        if (bound_on && (CNT_W'(left) < pick)) pick = CNT_W'(left);
        len = pick[LEN_W-1:0];
    end
endmodule

// File: rtl/dbs_timer.sv
// Per-transaction time budget: a prescaler turns clock cycles into 100 ns ticks.
// expire is high in the last cycle of a LIMIT*TICK_CYCLES window while run is high.
// Counters restart whenever run drops.
module dbs_timer #(
    parameter int TL_W        = 12,
    parameter int TICK_CYCLES = 10,
    localparam int SUB_W      = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TL_W-1:0] limit,
    output logic            expire
);
    logic [SUB_W-1:0] sub_q;
    logic [TL_W-1:0]  ticks_q;
    logic             sub_wrap;

    assign sub_wrap = (sub_q == SUB_W'(TICK_CYCLES - 1));
    assign expire   = run && (limit != '0) && sub_wrap && (ticks_q == limit - TL_W'(1));

    // Count cycles and ticks while a transaction runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q   <= '0;
            ticks_q <= '0;
        end else if (sub_wrap) begin
            sub_q   <= '0;
            ticks_q <= ticks_q + TL_W'(1);
        end else begin
            sub_q <= sub_q + SUB_W'(1);
        end
    end

    // R6
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (ticks_q < limit));
endmodule

// File: rtl/dbs_prio.sv
// Request priority. The automatic mode latches once the FIFO is seen empty on a
// write or full on a read; the latch is cleared when a new transfer is accepted.
module dbs_prio
    import dbs_pkg::*;
#(
    parameter int LVL_W      = 6,
    parameter int FIFO_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             busy,
    input  prio_e            mode,
    input  logic             dir_wr,
    input  logic [LVL_W-1:0] level,
    output logic             high
);
    logic flag_q;
    logic starved;

    assign starved = dir_wr ? (level == '0) : (level == LVL_W'(FIFO_DEPTH));
    assign high    = busy && ((mode == PRIO_HIGH) || ((mode == PRIO_AUTO) && flag_q));

    // Sticky automatic-raise flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) flag_q <= 1'b0;
        else if (busy && mode == PRIO_AUTO && starved) flag_q <= 1'b1;
    end

    // R11
    auto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flag_q && !clear) |=> flag_q);
endmodule

// File: rtl/dma_burst_sched.sv
// DMA burst and boundary scheduler. Waits for the FIFO level to cross the
// direction's threshold, requests one bus transaction of a computed length, counts
// bytes by beats, and repeats until the total is moved. Setup inputs are latched
// on the accepted start; FIFO level and thresholds are used live.
module dma_burst_sched
    import dbs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_W     = 8,
    parameter int LVL_W       = 6,
    parameter int FIFO_DEPTH  = 32,
    parameter int TL_W        = 12,
    parameter int TICK_CYCLES = 10,
    parameter int BC_W        = 4,
    parameter int BCODE_MAX   = 10,
    localparam int LEN_W      = BURST_W + 1,
    localparam int BOUND_W    = BCODE_MAX + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir_wr,
    input  logic [CNT_W-1:0]   total_bytes,
    input  logic [BURST_W-1:0] burst_bytes,
    input  logic [ADDR_W-1:0]  dev_addr,
    input  logic [BC_W-1:0]    bound_code,
    input  logic [TL_W-1:0]    time_limit,
    input  logic [1:0]         prio_sel,
    input  logic               scramble,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic [LVL_W-1:0]   tx_thresh,
    input  logic [LVL_W-1:0]   rx_thresh,
    input  logic               req_ready,
    input  logic               beat,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_bytes,
    output logic               xfer_active,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               prio_high
);
    sched_st_e          st;
    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   rem_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   moved_q;
    logic               dir_q;
    logic [BURST_W-1:0] burst_q;
    logic [BC_W-1:0]    bcode_q;
    logic [TL_W-1:0]    limit_q;
    prio_e              mode_q;
    logic               done_q;
    logic               err_q;

    logic [LEN_W-1:0]   len_w;
    logic               trigger;
    logic               expire;
    logic               accept;
    logic               last_beat;
    logic               xfer_end;
    logic [CNT_W-1:0]   rem_after;

    dbs_len_calc #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_W(BURST_W),
        .BC_W(BC_W), .BCODE_MAX(BCODE_MAX)
    ) u_len (
        .addr(addr_q), .remaining(rem_q), .burst(burst_q), .bcode(bcode_q), .len(len_w)
    );

    dbs_timer #(.TL_W(TL_W), .TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st == ST_MOVE), .limit(limit_q), .expire(expire)
    );

    dbs_prio #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_prio (
        .clk(clk), .rst_n(rst_n), .clear(accept), .busy(busy), .mode(mode_q),
        .dir_wr(dir_q), .level(fifo_level), .high(prio_high)
    );

    assign accept      = (st == ST_IDLE) && start;
    assign trigger     = dir_q ? (fifo_level < tx_thresh) : (fifo_level > rx_thresh);
    assign last_beat   = beat && (moved_q + LEN_W'(1) == len_q);
    assign xfer_end    = last_beat || expire;
    assign rem_after   = rem_q - CNT_W'(beat);

    assign busy        = (st != ST_IDLE);
    assign req_valid   = (st == ST_ISSUE);
    assign xfer_active = (st == ST_MOVE);
    assign req_addr    = addr_q;
    assign req_bytes   = len_q;
    assign done        = done_q;
    assign err         = err_q;

    // Transfer sequencing: latch setup, wait for level, request, count beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            len_q   <= '0;
            moved_q <= '0;
            dir_q   <= 1'b0;
            burst_q <= '0;
            bcode_q <= '0;
            limit_q <= '0;
            mode_q  <= PRIO_LOW;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    addr_q  <= dev_addr;
                    rem_q   <= total_bytes;
                    dir_q   <= dir_wr;
                    burst_q <= burst_bytes;
                    bcode_q <= bound_code;
                    limit_q <= time_limit;
                    mode_q  <= prio_e'(prio_sel);
                    if (scramble && dev_addr[1:0] != 2'b00) err_q <= 1'b1;
                    else if (total_bytes == '0)            done_q <= 1'b1;
                    else                                    st <= ST_WAIT;
                end
                ST_WAIT: if (trigger) begin
                    len_q <= len_w;
                    st    <= ST_ISSUE;
                end
                ST_ISSUE: if (req_ready) begin
                    moved_q <= '0;
                    st      <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (beat) begin
                        addr_q  <= addr_q + ADDR_W'(1);
                        rem_q   <= rem_after;
                        moved_q <= moved_q + LEN_W'(1);
                    end
                    if (xfer_end) begin
                        if (rem_after == '0) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Boundary span of the latched code, used by the checks below.
    logic [BOUND_W-1:0] chk_bs;
    logic [BOUND_W:0]   chk_end;
    always_comb begin
        chk_bs  = BOUND_W'(16) << bcode_q;
        chk_end = {1'b0, addr_q[BOUND_W-1:0] & (chk_bs - BOUND_W'(1))} + (BOUND_W + 1)'(len_q);
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_bytes)));

    // R4
    len_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_bytes != '0 && CNT_W'(req_bytes) <= rem_q));

    // R5
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bcode_q != '0 && bcode_q <= BC_W'(BCODE_MAX)) |-> (chk_end <= {1'b0, chk_bs}));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));

    // R7
    move_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && beat && !xfer_end) |=> (xfer_active && rem_q == $past(rem_q) - CNT_W'(1)));
endmodule

// File: tb/sim_dma_burst_sched.sv
// Bench: behavioural reference model compared every clock, plus per-test request lists.
module sim_dma_burst_sched;
    localparam int TICK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_wr = 1'b0;
    logic [23:0] total_bytes = '0;
    logic [7:0]  burst_bytes = '0;
    logic [31:0] dev_addr = '0;
    logic [3:0]  bound_code = '0;
    logic [11:0] time_limit = '0;
    logic [1:0]  prio_sel = '0;
    logic        scramble = 1'b0;
    logic [5:0]  fifo_level = '0;
    logic [5:0]  tx_thresh = '0;
    logic [5:0]  rx_thresh = '0;
    logic        req_ready = 1'b0;
    logic        beat = 1'b0;
    logic        req_valid, xfer_active, busy, done, err, prio_high;
    logic [31:0] req_addr;
    logic [8:0]  req_bytes;

    always #5 clk = ~clk;

    dma_burst_sched u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
        .total_bytes(total_bytes), .burst_bytes(burst_bytes), .dev_addr(dev_addr),
        .bound_code(bound_code), .time_limit(time_limit), .prio_sel(prio_sel),
        .scramble(scramble), .fifo_level(fifo_level), .tx_thresh(tx_thresh),
        .rx_thresh(rx_thresh), .req_ready(req_ready), .beat(beat),
        .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes),
        .xfer_active(xfer_active), .busy(busy), .done(done), .err(err),
        .prio_high(prio_high)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- bus responder ----------------
    bit beat_on = 1'b0;
    bit beat_alt = 1'b0;
    int ready_delay = 0;
    int wait_cnt = 0;
    int cyc_cnt = 0;
    always @(posedge clk) begin
        #2;
        cyc_cnt++;
        beat = beat_on && (!beat_alt || (cyc_cnt % 2 == 0));
        if (req_valid && !req_ready) begin
            if (wait_cnt >= ready_delay) req_ready = 1'b1;
            else wait_cnt++;
        end else begin
            req_ready = 1'b0;
            wait_cnt  = 0;
        end
    end

    // ---------------- reference model ----------------
    int m_mode = 0;  // 0 idle, 1 waiting for level, 2 requesting, 3 moving
    int m_addr, m_rem, m_len, m_moved, m_cyc, m_burst, m_bcode, m_limit, m_prio;
    bit m_dir, m_auto, m_done, m_err;
    bit m_live = 1'b0;

    function automatic int ref_len(int a, int r, int b, int c);
        int l, bs, lft;
        l = (b == 0) ? 256 : b;
        if (r < l) l = r;
        if (c >= 1 && c <= 10) begin
            bs  = 16 << c;
            lft = bs - (a % bs);
            if (lft < l) l = lft;
        end
        return l;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_done = 0; m_err = 0; m_auto = 0; m_live = 1'b1;
        end else begin
            if (m_mode != 0 && m_prio == 2 &&
                ((m_dir && fifo_level == 0) || (!m_dir && fifo_level == 32)))
                m_auto = 1;
            case (m_mode)
                0: if (start) begin
                    m_done = 0; m_err = 0; m_auto = 0;
                    m_addr = int'(dev_addr); m_rem = int'(total_bytes);
                    m_dir = dir_wr; m_burst = int'(burst_bytes); m_bcode = int'(bound_code);
                    m_limit = int'(time_limit); m_prio = int'(prio_sel);
                    if (scramble && dev_addr[1:0] != 0) m_err = 1;
                    else if (total_bytes == 0) m_done = 1;
                    else m_mode = 1;
                end
                1: if (m_dir ? (fifo_level < tx_thresh) : (fifo_level > rx_thresh)) begin
                    m_len  = ref_len(m_addr, m_rem, m_burst, m_bcode);
                    m_mode = 2;
                end
                2: if (req_ready) begin
                    m_moved = 0; m_cyc = 0; m_mode = 3;
                end
                default: begin
                    bit ended;
                    ended = 0;
                    if (beat) begin
                        m_addr++; m_rem--; m_moved++;
                        if (m_moved == m_len) ended = 1;
                    end
                    if (m_limit != 0 && m_cyc + 1 == m_limit * TICK) ended = 1;
                    m_cyc++;
                    if (ended) begin
                        if (m_rem == 0) begin m_mode = 0; m_done = 1; end
                        else m_mode = 1;
                    end
                end
            endcase
        end
    end

    // Compare every cycle; also log handshakes.
    int obs_a[$];
    int obs_l[$];
    always @(negedge clk) begin
        if (rst_n && m_live && !finished) begin
            bit e_prio;
            e_prio = (m_mode != 0) && (m_prio == 1 || (m_prio == 2 && m_auto));
            n_checks++;
            if (busy !== (m_mode != 0)) begin
                n_fail++; $display("FAIL R1 busy actual %0d expected %0d at %0t", busy, m_mode != 0, $time);
            end else if (req_valid !== (m_mode == 2)) begin
                n_fail++; $display("FAIL R2/R3 req_valid actual %0d expected %0d at %0t", req_valid, m_mode == 2, $time);
            end else if (xfer_active !== (m_mode == 3)) begin
                n_fail++; $display("FAIL R6 xfer_active actual %0d expected %0d at %0t", xfer_active, m_mode == 3, $time);
            end else if (m_mode == 2 && int'(req_bytes) != m_len) begin
                n_fail++; $display("FAIL R4 req_bytes actual %0d expected %0d at %0t", req_bytes, m_len, $time);
            end else if (m_mode == 2 && int'(req_addr) != m_addr) begin
                n_fail++; $display("FAIL R7 req_addr actual %0d expected %0d at %0t", req_addr, m_addr, $time);
            end else if (done !== m_done) begin
                n_fail++; $display("FAIL R8 done actual %0d expected %0d at %0t", done, m_done, $time);
            end else if (err !== m_err) begin
                n_fail++; $display("FAIL R10 err actual %0d expected %0d at %0t", err, m_err, $time);
            end else if (prio_high !== e_prio) begin
                n_fail++; $display("FAIL R11 prio_high actual %0d expected %0d at %0t", prio_high, e_prio, $time);
            end
            if (req_valid && req_ready) begin
                obs_a.push_back(int'(req_addr));
                obs_l.push_back(int'(req_bytes));
            end
        end
    end

    // ---------------- helpers ----------------
    int exp_a[$];
    int exp_l[$];

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic go(input bit d, input int tot, input int bst, input int a,
                      input int bc, input int lim, input int pr, input bit scr);
        obs_a.delete(); obs_l.delete(); exp_a.delete(); exp_l.delete();
        dir_wr = d; total_bytes = 24'(tot); burst_bytes = 8'(bst); dev_addr = 32'(a);
        bound_code = 4'(bc); time_limit = 12'(lim); prio_sel = 2'(pr); scramble = scr;
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic finish_xfer();
        int guard;
        guard = 0;
        while (busy && guard < 5000) begin tick(1); guard++; end
        tick(3);
    endtask

    task automatic want(input int a, input int l);
        exp_a.push_back(a); exp_l.push_back(l);
    endtask

    task automatic verify_list(input string tag);
        check(obs_a.size() == exp_a.size(), {tag, " request count"}, obs_a.size(), exp_a.size());
        if (obs_a.size() == exp_a.size())
            foreach (exp_a[i]) begin
                check(obs_a[i] == exp_a[i], {tag, " request addr"}, obs_a[i], exp_a[i]);
                check(obs_l[i] == exp_l[i], {tag, " request length"}, obs_l[i], exp_l[i]);
            end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- tests ----------------
    initial begin
        tick(4);
        @(negedge clk);
        // R13 reset state
        check(!busy && !done && !err && !req_valid && !xfer_active && !prio_high,
              "R13 reset outputs", int'({busy, done, err, req_valid, xfer_active, prio_high}), 0);
        rst_n = 1'b1;
        tick(2);

        // R2 + R4: read, burst-limited split, stray beats before start (R7)
        beat_on = 1'b1; rx_thresh = 6'd3; fifo_level = 6'd3; tick(4);
        go(1'b0, 100, 32, 'h100, 0, 0, 0, 1'b0);
        tick(6);
        check(!req_valid, "R2 no request at level equal to threshold", req_valid, 0);
        fifo_level = 6'd4;
        finish_xfer();
        check(done, "R8 done after read", done, 1);
        want('h100, 32); want('h120, 32); want('h140, 32); want('h160, 4);
        verify_list("R4 burst split");

        // R3: write gated by level, R12 delayed ready, R1 second start ignored
        tx_thresh = 6'd4; fifo_level = 6'd4; ready_delay = 3;
        go(1'b1, 40, 32, 'h2000, 0, 0, 0, 1'b0);
        tick(6);
        check(!req_valid, "R3 no request at level equal to threshold", req_valid, 0);
        fifo_level = 6'd3;
        tick(3);
        @(negedge clk);
        check(req_valid && !req_ready, "R12 request held while not ready", req_valid, 1);
        tick(1);
        start = 1'b1; total_bytes = 24'd7; tick(1); start = 1'b0;
        finish_xfer();
        want('h2000, 32); want('h2020, 8);
        verify_list("R1 start while busy ignored");
        ready_delay = 0;

        // R5: 32-byte boundary from an unaligned address
        fifo_level = 6'd10;
        go(1'b0, 70, 32, 'h1C, 1, 0, 0, 1'b0);
        finish_xfer();
        want('h1C, 4); want('h20, 32); want('h40, 32); want('h60, 2);
        verify_list("R5 32 B boundary");

        // R5: 16 KB boundary near its edge
        go(1'b0, 40, 32, 'h3FF0, 10, 0, 0, 1'b0);
        finish_xfer();
        want('h3FF0, 16); want('h4000, 24);
        verify_list("R5 16 KB boundary");

        // R5: code above 10 disables splitting
        go(1'b0, 40, 32, 'h1C, 11, 0, 0, 1'b0);
        finish_xfer();
        want('h1C, 32); want('h3C, 8);
        verify_list("R5 out-of-range code");

        // R4: burst size 0 means 256
        go(1'b0, 300, 0, 'h0, 0, 0, 0, 1'b0);
        finish_xfer();
        want('h0, 256); want('h100, 44);
        verify_list("R4 burst zero");

        // R6: time budget cuts transactions with slow beats
        beat_alt = 1'b1;
        go(1'b0, 32, 32, 'h400, 0, 1, 0, 1'b0);
        finish_xfer();
        check(obs_a.size() >= 3, "R6 transactions cut by budget", obs_a.size(), 3);
        check(obs_a.size() >= 2 && obs_a[1] > 'h400 && obs_a[1] < 'h420,
              "R6 resumed address", obs_a.size() >= 2 ? obs_a[1] : -1, 'h40A);
        check(done, "R6 transfer still completes", done, 1);
        beat_alt = 1'b0;

        // R9: zero total
        go(1'b0, 0, 32, 'h0, 0, 0, 0, 1'b0);
        @(negedge clk);
        check(done && !busy, "R9 zero-length done", int'({done, busy}), 2);
        tick(3);
        check(obs_a.size() == 0, "R9 no request", obs_a.size(), 0);

        // R10: misaligned scramble refused, aligned accepted
        go(1'b0, 8, 32, 'h102, 0, 0, 0, 1'b1);
        @(negedge clk);
        check(err && !busy && !done, "R10 misaligned scramble", int'({err, busy, done}), 4);
        tick(3);
        go(1'b0, 8, 32, 'h104, 0, 0, 0, 1'b1);
        @(negedge clk);
        check(!err && busy, "R10 aligned scramble proceeds", int'({err, busy}), 1);
        finish_xfer();
        check(done && !err, "R10 aligned scramble completes", int'({done, err}), 2);

        // R11: priority modes
        go(1'b0, 64, 32, 'h0, 0, 0, 1, 1'b0);
        @(negedge clk);
        check(prio_high, "R11 high mode", prio_high, 1);
        finish_xfer();
        check(!prio_high, "R11 idle is low", prio_high, 0);
        fifo_level = 6'd0; tx_thresh = 6'd4;
        go(1'b1, 64, 32, 'h0, 0, 0, 2, 1'b0);
        tick(3);
        @(negedge clk);
        check(prio_high, "R11 auto raised on empty TX FIFO", prio_high, 1);
        finish_xfer();
        fifo_level = 6'd20; rx_thresh = 6'd3;
        go(1'b0, 64, 32, 'h0, 0, 0, 2, 1'b0);
        tick(3);
        @(negedge clk);
        check(!prio_high, "R11 auto stays low when RX not full", prio_high, 0);
        finish_xfer();
        go(1'b0, 16, 32, 'h0, 0, 0, 3, 1'b0);
        @(negedge clk);
        check(!prio_high, "R11 code 3 acts as low", prio_high, 0);
        finish_xfer();

        // R7: beats while idle leave nothing behind
        tick(10);
        @(negedge clk);
        check(!busy && !req_valid, "R7 idle beats ignored", int'({busy, req_valid}), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule